// File: doc/BRIEF.md
# Oversampled Bit-Distortion Checker

This block recovers bits from one asynchronous serial line and judges how distorted each bit is. The sample clock runs at 32 times the bit rate. The line passes through a two-stage synchronizer. While a message controller holds the enable high, the block waits for the idle-HIGH line to fall. It treats that falling edge as the start of a start bit, and the start bit fixes the 32-sample window for every later bit of the message.

For each window the block counts the HIGH samples. A bit is accepted as HIGH when the LOW samples stay within a programmable tolerance, and as LOW when the HIGH samples stay within it. Any count between those two bands is a distortion error. The recovered bit is always the majority value. The error flag stays set until reset.

When the controller drops the enable, the message has ended. The block then watches the line for two bit periods, and any change during that gap is an error. In synchronous operation the checker is bypassed and stays idle.

Top module: `dbc_checker`

## Requirements
- R1: `rst` is synchronous and active high. After reset, `bit_valid` and `bit_err` are 0 and `bit_out` is 1. The synchronizer holds HIGH, so the block is idle and needs a fresh falling edge.
- R2: The line is resynchronized through two flops. The block starts a start window on a synchronized HIGH-to-LOW step only while idle with `en`=1 and `async_mode`=1. The first LOW sample is sample 0 of that window.
- R3: The start window has 32 samples. A start bit with at most the tolerance count of HIGH samples is accepted, and the data windows then follow back to back, 32 samples each, from the next sample on. A start bit that fails this test is dropped with no strobe and no error, and the block waits for the next falling edge.
- R4: `tol_sel` gives the allowed number of wrong-level samples per 32: 2'b00 allows 6, 2'b01 allows 8, 2'b10 allows 10, 2'b11 allows 12. It is sampled on the clock edge that registers the decision.
- R5: For each data window, `bit_valid` pulses for one cycle. The pulse follows the clock edge two cycles after the edge at which the window's last sample was applied to `rx`. If the LOW count is at most the tolerance, `bit_out`=1. If the HIGH count is at most the tolerance, `bit_out`=0.
- R6: A data window whose count is in neither band still pulses `bit_valid`, and it sets `bit_err` on that same edge. In that case `bit_out` is 1 when 16 or more samples were HIGH and 0 otherwise. `bit_err` then stays 1 until `rst`.
- R7: If `en` falls during data windows, the open window is discarded and the block watches 64 synchronized samples. Any difference between consecutive samples in that span sets `bit_err`. `en` has no effect during the span, and the block returns to idle at its end.
- R8: While `async_mode` is 0, the block is forced idle. It produces no strobe and no error, whatever `rx` does.
- R9: While `en` is 0 in idle, falling edges on `rx` start no window.
- R10: `bit_out` keeps the last decided value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 32 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Message enable from the message controller |
| async_mode | input | 1 | 1 = asynchronous checking active, 0 = bypassed |
| rx | input | 1 | Serial line, idle HIGH |
| tol_sel | input | 2 | Distortion tolerance select |
| bit_out | output | 1 | Recovered (majority) bit value |
| bit_valid | output | 1 | One-cycle strobe per decided data bit |
| bit_err | output | 1 | Sticky distortion or gap error |

## Verification
Every result is due two clock edges after the `rx` sample that causes it. The decision for a window comes two edges after that window's last sample is applied. A gap transition sets `bit_err` two edges after the offending sample, and a start edge is seen two edges after the first LOW sample. The bench's reference model feeds its sample stream through a two-entry delay of its own and advances once per clock. Outputs are compared at the falling clock edge after each rising edge, so every comparison meets the registered result in the cycle it appears. A separate scoreboard holds the bit values the stimulus intended and matches them against each strobe. After each scenario the bench also checks the strobe count and the sticky error flag.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_GAP   = 2'd3
  } dbc_state_e;
endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dbc_judge.sv
module dbc_judge #(
  parameter  int OVS      = 32,
  parameter  int TOL_BASE = 6,
  parameter  int TOL_STEP = 2,
  localparam int HI_W     = $clog2(OVS + 1)
) (
  input  logic [HI_W-1:0] hi_total,
  input  logic [1:0]      tol_sel,
  output logic            is_high,
  output logic            is_low,
  output logic            maj
);
  logic [HI_W-1:0] tol;
  logic [HI_W-1:0] lo_total;

  // R4: allowed wrong-level samples grow linearly with the select code
  always_comb begin
    tol      = HI_W'(TOL_BASE) + HI_W'(TOL_STEP) * HI_W'(tol_sel);
    lo_total = HI_W'(OVS) - hi_total;
    is_high  = (lo_total <= tol);
    is_low   = (hi_total <= tol);
    maj      = (hi_total >= HI_W'(OVS / 2));
  end
endmodule

// File: rtl/dbc_ctrl.sv
module dbc_ctrl
  import dbc_pkg::*;
#(
  parameter  int OVS      = 32,
  parameter  int GAP_BITS = 2,
  localparam int HI_W     = $clog2(OVS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            async_mode,
  input  logic            smp,
  input  logic            is_high,
  input  logic            is_low,
  input  logic            maj,
  output logic [HI_W-1:0] hi_total,
  output logic            bit_out,
  output logic            bit_valid,
  output logic            bit_err
);
  localparam int CNT_W   = $clog2(OVS);
  localparam int GAP_LEN = GAP_BITS * OVS;
  localparam int GAP_W   = $clog2(GAP_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_LEN - 1);

  dbc_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  hi_cnt;
  logic [GAP_W-1:0] gcnt;
  logic             prev;
  logic             last;
  logic             fall;

  assign hi_total = hi_cnt + HI_W'(smp);
  assign last     = (cnt == CNT_LAST);
  assign fall     = prev & ~smp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hi_cnt    <= '0;
      gcnt      <= '0;
      prev      <= 1'b1;
      bit_out   <= 1'b1;
      bit_valid <= 1'b0;
      bit_err   <= 1'b0;
    end else begin
      prev      <= smp;
      bit_valid <= 1'b0;
      if (!async_mode) begin
        state <= ST_IDLE;                      // R8
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (en && fall) begin              // R2, R9
              state  <= ST_START;
              cnt    <= CNT_W'(1);
              hi_cnt <= '0;
            end
          end
          ST_START: begin
            if (!en) begin
              state <= ST_IDLE;
            end else if (last) begin           // R3
              state  <= is_low ? ST_DATA : ST_IDLE;
              cnt    <= '0;
              hi_cnt <= '0;
            end else begin
              cnt    <= cnt + CNT_W'(1);
              hi_cnt <= hi_total;
            end
          end
          ST_DATA: begin
            if (!en) begin                     // R7
              state <= ST_GAP;
              gcnt  <= '0;
            end else if (last) begin           // R5, R6
              bit_valid <= 1'b1;
              bit_out   <= maj;
              if (!is_high && !is_low) bit_err <= 1'b1;
              cnt    <= '0;
              hi_cnt <= '0;
            end else begin
              cnt    <= cnt + CNT_W'(1);
              hi_cnt <= hi_total;
            end
          end
          ST_GAP: begin
            if (smp != prev) bit_err <= 1'b1;  // R7
            if (gcnt == GAP_LAST) state <= ST_IDLE;
            gcnt <= gcnt + GAP_W'(1);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);                                          // R3
  AST_STROBE_AT_WINDOW_END: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> ($past(cnt) == CNT_LAST && $past(state) == ST_DATA)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    bit_err |=> bit_err);                                               // R6
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !async_mode |=> !bit_valid);                                        // R8
  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(is_high && is_low));                                              // R4
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_err) |-> (bit_valid || $past(state) == ST_GAP));          // R7
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
  parameter int OVS         = 32,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_BITS    = 2,
  parameter int TOL_BASE    = 6,
  parameter int TOL_STEP    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       async_mode,
  input  logic       rx,
  input  logic [1:0] tol_sel,
  output logic       bit_out,
  output logic       bit_valid,
  output logic       bit_err
);
  localparam int HI_W = $clog2(OVS + 1);

  logic            smp;
  logic [HI_W-1:0] hi_total;
  logic            is_high;
  logic            is_low;
  logic            maj;

  dbc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx),
    .dout (smp)
  );

  dbc_judge #(.OVS(OVS), .TOL_BASE(TOL_BASE), .TOL_STEP(TOL_STEP)) u_judge (
    .hi_total (hi_total),
    .tol_sel  (tol_sel),
    .is_high  (is_high),
    .is_low   (is_low),
    .maj      (maj)
  );

  dbc_ctrl #(.OVS(OVS), .GAP_BITS(GAP_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .async_mode (async_mode),
    .smp        (smp),
    .is_high    (is_high),
    .is_low     (is_low),
    .maj        (maj),
    .hi_total   (hi_total),
    .bit_out    (bit_out),
    .bit_valid  (bit_valid),
    .bit_err    (bit_err)
  );
endmodule

// File: tb/dbc_checker_bench.sv
module dbc_checker_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       async_mode = 1'b1;
  logic       rx = 1'b1;
  logic [1:0] tol_sel = 2'b00;
  logic       bit_out, bit_valid, bit_err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbc_checker u_dbc_checker (
    .clk(clk), .rst(rst), .en(en), .async_mode(async_mode), .rx(rx),
    .tol_sel(tol_sel), .bit_out(bit_out), .bit_valid(bit_valid), .bit_err(bit_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int hist[$];
  int m_phase, m_pos, m_ones, m_gap, m_last;
  int e_out, e_valid, e_err;
  int exp_q[$];
  int strobes;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int s, total, tol;
    if (rst) begin
      m_phase = 0; m_pos = 0; m_ones = 0; m_gap = 0; m_last = 1;
      e_out = 1; e_valid = 0; e_err = 0;
      hist.delete();
      hist.push_back(1);
      hist.push_back(1);
      return;
    end
    hist.push_back(int'(rx));
    s = hist[hist.size() - 3];
    if (hist.size() > 3) void'(hist.pop_front());
    tol = 6 + 2 * int'(tol_sel);
    total = m_ones + s;
    e_valid = 0;
    if (!async_mode) m_phase = 0;
    else if (m_phase == 0) begin
      if (en && m_last == 1 && s == 0) begin m_phase = 1; m_pos = 1; m_ones = 0; end
    end else if (m_phase == 1) begin
      if (!en) m_phase = 0;
      else if (m_pos == 31) begin
        m_phase = (total <= tol) ? 2 : 0; m_pos = 0; m_ones = 0;
      end else begin m_pos++; m_ones = total; end
    end else if (m_phase == 2) begin
      if (!en) begin m_phase = 3; m_gap = 0; end
      else if (m_pos == 31) begin
        e_valid = 1;
        e_out = (total >= 16) ? 1 : 0;
        if ((32 - total) > tol && total > tol) e_err = 1;
        m_pos = 0; m_ones = 0;
      end else begin m_pos++; m_ones = total; end
    end else begin
      if (s != m_last) e_err = 1;
      if (m_gap == 63) m_phase = 0;
      m_gap++;
    end
    m_last = s;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("R5", int'(bit_valid), e_valid);
    chk("R10", int'(bit_out), e_out);
    chk("R6", int'(bit_err), e_err);
    if (bit_valid && !rst) begin
      strobes++;
      if (exp_q.size() == 0) chk("R5 unexpected strobe", 1, 0);
      else chk("R5 scoreboard", int'(bit_out), exp_q.pop_front());
    end
  endtask

  task automatic drive(logic v);
    rx = v;
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  // wrong samples at the end for start bits, at the beginning for data bits
  task automatic send_win(logic v, int wrong, bit is_data);
    int highs;
    for (int i = 0; i < 32; i++) begin
      bit w;
      w = is_data ? (i < wrong) : (i >= 32 - wrong);
      drive(w ? ~v : v);
    end
    highs = v ? 32 - wrong : wrong;
    if (is_data) exp_q.push_back(highs >= 16 ? 1 : 0);
  endtask

  task automatic end_msg();
    idle(3);
    en = 1'b0;
    idle(70);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx = 1'b1;
    en = 1'b0;
    cyc(); cyc(); cyc();
    rst = 1'b0;
    exp_q.delete();
    strobes = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", int'(bit_valid), 0);
    chk("R1", int'(bit_err), 0);
    chk("R1", int'(bit_out), 1);

    // R2 R3 R5: clean message, quiet gap
    en = 1'b1; async_mode = 1'b1; tol_sel = 2'b00;
    idle(10);
    send_win(1'b0, 0, 0);
    send_win(1'b1, 0, 1);
    send_win(1'b0, 0, 1);
    send_win(1'b1, 0, 1);
    send_win(1'b0, 0, 1);
    send_win(1'b1, 0, 1);
    end_msg();
    chk("R5 strobe count", strobes, 5);
    chk("R7 quiet gap", int'(bit_err), 0);
    chk("R10 hold", int'(bit_out), 1);

    // R4: each tolerance at and beyond its limit
    for (int t = 0; t < 4; t++) begin
      int tw;
      tw = 6 + 2 * t;
      do_reset();
      tol_sel = 2'(t); en = 1'b1;
      idle(8);
      send_win(1'b0, tw, 0);
      send_win(1'b1, tw, 1);
      send_win(1'b0, tw, 1);
      send_win(1'b1, 0, 1);
      end_msg();
      chk("R4 at limit err", int'(bit_err), 0);
      chk("R4 at limit strobes", strobes, 3);
      do_reset();
      tol_sel = 2'(t); en = 1'b1;
      idle(8);
      send_win(1'b0, 0, 0);
      send_win(1'b1, tw + 1, 1);
      send_win(1'b0, tw + 1, 1);
      send_win(1'b1, 0, 1);
      end_msg();
      chk("R4 beyond limit err", int'(bit_err), 1);
      chk("R4 beyond limit strobes", strobes, 3);
    end

    // R6: majority on errored bits, sticky flag
    do_reset();
    tol_sel = 2'b00; en = 1'b1;
    idle(8);
    send_win(1'b0, 0, 0);
    send_win(1'b1, 16, 1);
    send_win(1'b0, 15, 1);
    send_win(1'b1, 7, 1);
    send_win(1'b1, 0, 1);
    end_msg();
    chk("R6 sticky", int'(bit_err), 1);
    chk("R6 strobes", strobes, 4);

    // R3: rejected start bit re-arms
    do_reset();
    tol_sel = 2'b01; en = 1'b1;
    idle(8);
    send_win(1'b0, 9, 0);
    idle(10);
    chk("R3 rejected start", strobes, 0);
    chk("R3 rejected start err", int'(bit_err), 0);
    send_win(1'b0, 0, 0);
    send_win(1'b0, 0, 1);
    send_win(1'b1, 0, 1);
    end_msg();
    chk("R3 rearm strobes", strobes, 2);

    // R7: transition in the gap
    do_reset();
    tol_sel = 2'b00; en = 1'b1;
    idle(8);
    send_win(1'b0, 0, 0);
    send_win(1'b1, 0, 1);
    idle(3);
    en = 1'b0;
    idle(10);
    chk("R7 before glitch", int'(bit_err), 0);
    en = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b0);
    idle(60);
    chk("R7 gap glitch", int'(bit_err), 1);
    en = 1'b0;
    idle(10);

    // R8: bypassed in synchronous operation
    do_reset();
    async_mode = 1'b0; en = 1'b1;
    idle(8);
    send_win(1'b0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      rx = 1'b1; cyc(); rx = 1'b0; cyc();
    end
    idle(100);
    chk("R8 no strobe", strobes, 0);
    chk("R8 no error", int'(bit_err), 0);
    async_mode = 1'b1;

    // R9: no start while enable low
    do_reset();
    en = 1'b0;
    idle(8);
    for (int i = 0; i < 40; i++) drive(1'b0);
    idle(40);
    en = 1'b1;
    idle(80);
    chk("R9 no strobe", strobes, 0);
    chk("R9 no error", int'(bit_err), 0);
    send_win(1'b0, 0, 0);
    send_win(1'b0, 0, 1);
    send_win(1'b1, 0, 1);
    end_msg();
    chk("R9 later message", strobes, 2);
    chk("R5 queue drained", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule